// File: doc/BRIEF.md
# Dual-Line Asynchronous Serial Frame Monitor

This block watches two asynchronous serial lines, one receive and one transmit, and decodes the character frames on them without driving anything. Each line has its own framing engine. Both engines share one set of configuration pins: the bit period, the character length, the parity rule and the bit order. The block runs on a sample clock that is much faster than the baud rate. Both line inputs are taken as already synchronous to that clock.

For each decoded frame the line's engine gives a one-cycle result. The result holds the character, right-aligned, a channel tag and three error flags (start, parity, stop). A malformed frame is still reported, with its flags set, and is not dropped. Results are not held: there is no ready input, and a consumer must take each result in the cycle its valid is high. A frame on the wire cannot be held back, so back-pressure is not possible. The two result ports are separate, so both channels may report in the same cycle.

Top module: `uart_frame_monitor`

## Requirements
- R1: A frame starts when the line is high at one sample and low at the next while that engine is idle. The first sample after reset only records the line level, so a line that is already low when reset is released starts no frame.
- R2: `cfg_period` gives the bit period in samples as an unsigned fixed-point value with 8 fractional bits. Bit n is sampled at the first sample whose distance from the start-edge sample is at least period/2 + n*period. Bit 0 is the start bit, then come the data bits, then the parity bit (when enabled), then the stop bit.
- R3: `cfg_len` sets the character length, 5 to 9 bits. The character is reported right-aligned in the data output, and all bits above the length are zero.
- R4: With `cfg_msb_first` = 0, the first data bit on the wire is bit 0 of the character. With `cfg_msb_first` = 1, it is bit `cfg_len`-1.
- R5: `cfg_parity` encodes 0 = none, 1 = odd, 2 = even, 3 = always zero, 4 = always one. Flag bit 1 is set when the parity bit breaks the rule. For odd and even, the rule counts the ones over the data bits and the parity bit together.
- R6: With parity none, no parity bit is read. The stop bit is taken at position `cfg_len`+1, and flag bit 1 is 0.
- R7: Flag bit 0 is set when the start bit reads 1 at its centre. The rest of the frame is still decoded and reported.
- R8: Exactly one stop bit is read. Flag bit 2 is set when it reads 0.
- R9: Each completed frame raises its channel's valid for exactly one cycle, the cycle after the stop-bit sample. The channel tag is 0 on the receive port and 1 on the transmit port. The two lines are decoded independently and may complete in the same cycle.
- R10: During and right after reset, both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Receive line sample, idle high |
| tx_line | input | 1 | Transmit line sample, idle high |
| cfg_period | input | PERIOD_W (20) | Bit period in samples, 8 fractional bits |
| cfg_len | input | LEN_W (4) | Character length, 5 to 9 |
| cfg_parity | input | 3 | Parity rule code |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| rx_valid | output | 1 | Receive result strobe |
| rx_chan | output | 1 | Receive result channel tag (0) |
| rx_data | output | DATA_W (9) | Receive character |
| rx_flags | output | 3 | Receive flags {stop, parity, start} |
| tx_valid | output | 1 | Transmit result strobe |
| tx_chan | output | 1 | Transmit result channel tag (1) |
| tx_data | output | DATA_W (9) | Transmit character |
| tx_flags | output | 3 | Transmit flags {stop, parity, start} |

## Verification
Characters with uneven bit patterns are sent in both bit orders. This separates a correct shift direction from a mirrored one, and a length of 5 or 9 bits exposes a wrong insertion point. Frames are sent under each parity rule, with a correct parity bit and with a flipped one. This tells apart the odd and even rules, the constant rules, and the shifted stop position when parity is none. A shortened start bit and a low stop bit each set their own flag while the character stays intact. Frames at periods of 6.5 and 5.75 samples, 12 bits long, show whether fractional timing drifts out of the bit. Simultaneous frames on both lines, and a line held low out of reset, check that the channels are independent and that the first sample does not count as an edge.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

  localparam int FRAC_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } lane_state_e;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } parity_e;

endpackage

// File: rtl/uart_mon_timer.sv
module uart_mon_timer #(
  parameter int PW = 20,
  parameter int EW = PW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          advance,
  input  logic [PW-1:0] period,
  output logic          hit
);
  import uart_mon_pkg::*;

  localparam logic [EW-1:0] ONE_SAMPLE = EW'(1) << FRAC_BITS;

  logic [EW-1:0] elapsed_q;
  logic [EW-1:0] target_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      target_q  <= '0;
    end else if (restart) begin
      elapsed_q <= ONE_SAMPLE;
      target_q  <= EW'(period >> 1);
    end else begin
      if (run)     elapsed_q <= elapsed_q + ONE_SAMPLE;
      if (advance) target_q  <= target_q + EW'(period);
    end
  end

  assign hit = run && (elapsed_q >= target_q);

endmodule

// File: rtl/uart_mon_parity.sv
module uart_mon_parity #(
  parameter int DW = 9
) (
  input  logic [DW-1:0]          data,
  input  logic                   pbit,
  input  uart_mon_pkg::parity_e  mode,
  output logic                   ok
);
  import uart_mon_pkg::*;

  logic odd_ones;
  assign odd_ones = (^data) ^ pbit;

  always_comb begin
    unique case (mode)
      PAR_ODD:  ok = odd_ones;
      PAR_EVEN: ok = !odd_ones;
      PAR_ZERO: ok = !pbit;
      PAR_ONE:  ok = pbit;
      default:  ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_mon_lane.sv
module uart_mon_lane #(
  parameter int PW = 20,
  parameter int DW = 9,
  parameter int LW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line,
  input  logic [PW-1:0]         cfg_period,
  input  logic [LW-1:0]         cfg_len,
  input  uart_mon_pkg::parity_e cfg_parity,
  input  logic                  cfg_msb_first,
  output logic                  res_valid,
  output logic [DW-1:0]         res_data,
  output logic [2:0]            res_flags
);
  import uart_mon_pkg::*;

  lane_state_e   state_q;
  logic          prev_line_q;
  logic          prev_vld_q;
  logic [DW-1:0] shreg_q;
  logic [LW-1:0] bit_idx_q;
  logic          f_start_q;
  logic          f_par_q;

  logic          fall;
  logic          run;
  logic          restart;
  logic          advance;
  logic          hit;
  logic          par_ok;
  logic [DW-1:0] shift_nxt;
  logic [LW-1:0] last_idx;

  assign fall     = prev_vld_q && prev_line_q && !line;
  assign run      = (state_q != ST_IDLE);
  assign restart  = (state_q == ST_IDLE) && fall;
  assign last_idx = cfg_len - LW'(1);
  assign advance  = hit && ((state_q == ST_START) || (state_q == ST_DATA) ||
                            ((state_q == ST_PAR) && (cfg_parity != PAR_NONE)));

  always_comb begin
    if (cfg_msb_first) shift_nxt = {shreg_q[DW-2:0], line};
    else               shift_nxt = (shreg_q >> 1) | (DW'(line) << last_idx);
  end

  uart_mon_timer #(.PW(PW), .EW(PW + 4)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .advance (advance),
    .period  (cfg_period),
    .hit     (hit)
  );

  uart_mon_parity #(.DW(DW)) parity_i (
    .data (shreg_q),
    .pbit (line),
    .mode (cfg_parity),
    .ok   (par_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      prev_line_q <= 1'b1;
      prev_vld_q  <= 1'b0;
      shreg_q     <= '0;
      bit_idx_q   <= '0;
      f_start_q   <= 1'b0;
      f_par_q     <= 1'b0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_flags   <= '0;
    end else begin
      prev_line_q <= line;
      prev_vld_q  <= 1'b1;
      res_valid   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fall) state_q <= ST_START;
        ST_START: if (hit) begin
          f_start_q <= line;
          f_par_q   <= 1'b0;
          shreg_q   <= '0;
          bit_idx_q <= '0;
          state_q   <= ST_DATA;
        end
        ST_DATA: if (hit) begin
          shreg_q <= shift_nxt;
          if (bit_idx_q == last_idx) state_q <= ST_PAR;
          else bit_idx_q <= bit_idx_q + LW'(1);
        end
        ST_PAR: begin
          if (cfg_parity == PAR_NONE) begin
            state_q <= ST_STOP;
          end else if (hit) begin
            f_par_q <= !par_ok;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: if (hit) begin
          res_valid <= 1'b1;
          res_data  <= shreg_q;
          res_flags <= {!line, f_par_q, f_start_q};
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_frame_monitor.sv
module uart_frame_monitor #(
  parameter int PERIOD_W = 20,
  parameter int DATA_W   = 9,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_line,
  input  logic                tx_line,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [2:0]          cfg_parity,
  input  logic                cfg_msb_first,
  output logic                rx_valid,
  output logic                rx_chan,
  output logic [DATA_W-1:0]   rx_data,
  output logic [2:0]          rx_flags,
  output logic                tx_valid,
  output logic                tx_chan,
  output logic [DATA_W-1:0]   tx_data,
  output logic [2:0]          tx_flags
);
  import uart_mon_pkg::*;

  localparam int NCH = 2;

  logic [NCH-1:0]             lines;
  logic [NCH-1:0]             valids;
  logic [NCH-1:0][DATA_W-1:0] datas;
  logic [NCH-1:0][2:0]        flags;
  parity_e                    par_mode;

  assign lines    = {tx_line, rx_line};
  assign par_mode = parity_e'(cfg_parity);

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    uart_mon_lane #(.PW(PERIOD_W), .DW(DATA_W), .LW(LEN_W)) lane_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .line          (lines[g]),
      .cfg_period    (cfg_period),
      .cfg_len       (cfg_len),
      .cfg_parity    (par_mode),
      .cfg_msb_first (cfg_msb_first),
      .res_valid     (valids[g]),
      .res_data      (datas[g]),
      .res_flags     (flags[g])
    );
  end

  assign rx_valid = valids[0];
  assign rx_chan  = 1'b0;
  assign rx_data  = datas[0];
  assign rx_flags = flags[0];
  assign tx_valid = valids[1];
  assign tx_chan  = 1'b1;
  assign tx_data  = datas[1];
  assign tx_flags = flags[1];

endmodule

// File: rtl/uart_frame_monitor_sva.sv
module uart_frame_monitor_sva #(
  parameter int DATA_W = 9,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_line,
  input logic              tx_line,
  input logic [LEN_W-1:0]  cfg_len,
  input logic [2:0]        cfg_parity,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic [2:0]        rx_flags,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic [2:0]        tx_flags
);

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9
  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid); // R9
  AST_RX_DATA_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> cfg_len) == '0)); // R3
  AST_TX_DATA_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((tx_data >> cfg_len) == '0)); // R3
  AST_RX_NOPAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_parity == 3'd0) |-> !rx_flags[1]); // R6
  AST_TX_NOPAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && cfg_parity == 3'd0) |-> !tx_flags[1]); // R6
  AST_RX_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_flags[2] == !$past(rx_line))); // R8
  AST_TX_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_flags[2] == !$past(tx_line))); // R8

endmodule

bind uart_frame_monitor uart_frame_monitor_sva #(.DATA_W(DATA_W), .LEN_W(LEN_W)) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_line    (rx_line),
  .tx_line    (tx_line),
  .cfg_len    (cfg_len),
  .cfg_parity (cfg_parity),
  .rx_valid   (rx_valid),
  .rx_data    (rx_data),
  .rx_flags   (rx_flags),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_flags   (tx_flags)
);

// File: tb/uart_frame_monitor_tb_top.sv
module uart_frame_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b0;
  logic        tx_line = 1'b1;
  logic [19:0] cfg_period = 20'd2048;
  logic [3:0]  cfg_len = 4'd8;
  logic [2:0]  cfg_parity = 3'd0;
  logic        cfg_msb_first = 1'b0;
  logic        rx_valid, rx_chan, tx_valid, tx_chan;
  logic [8:0]  rx_data, tx_data;
  logic [2:0]  rx_flags, tx_flags;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [11:0] q_rx[$];
  logic [11:0] q_tx[$];
  string       t_rx[$];
  string       t_tx[$];

  always #5 clk = ~clk;

  uart_frame_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tx_line(tx_line),
    .cfg_period(cfg_period), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_msb_first(cfg_msb_first),
    .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_data(rx_data), .rx_flags(rx_flags),
    .tx_valid(tx_valid), .tx_chan(tx_chan), .tx_data(tx_data), .tx_flags(tx_flags)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Driver: push the expected result, then drive the frame sample by sample.
  task automatic send_frame(input int ch, input int val, input int len, input int par,
                            input bit msb, input bit bad_start, input bit bad_par,
                            input bit bad_stop, input string tag);
    logic bits [0:12];
    int   nb;
    int   s;
    int   ones;
    logic pb;
    logic [8:0] mask;
    logic [8:0] dv;
    logic [2:0] fl;
    mask = 9'((1 << len) - 1);
    dv = 9'(val) & mask;
    ones = $countones(dv);
    bits[0] = 1'b0;
    for (int i = 0; i < len; i++) bits[1 + i] = msb ? dv[len - 1 - i] : dv[i];
    nb = 1 + len;
    if (par != 0) begin
      case (par)
        1: pb = (ones % 2 == 0);
        2: pb = (ones % 2 == 1);
        3: pb = 1'b0;
        default: pb = 1'b1;
      endcase
      bits[nb] = pb ^ bad_par;
      nb++;
    end
    bits[nb] = !bad_stop;
    nb++;
    fl = {bad_stop, (par != 0) && bad_par, bad_start};
    if (ch == 0) begin q_rx.push_back({fl, dv}); t_rx.push_back(tag); end
    else         begin q_tx.push_back({fl, dv}); t_tx.push_back(tag); end
    s = 0;
    for (int k = 0; k < nb; k++) begin
      int bnd;
      bnd = int'((longint'(k + 1) * longint'(cfg_period)) >>> 8);
      while (s < bnd) begin
        logic v;
        v = bits[k];
        if (k == 0 && bad_start && s > 0) v = 1'b1;
        if (ch == 0) rx_line = v; else tx_line = v;
        @(negedge clk);
        s++;
      end
    end
    if (ch == 0) rx_line = 1'b1; else tx_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pop and compare as results appear.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rx_valid) begin
        if (q_rx.size() == 0) begin
          check(0, "R1", "unexpected rx result", int'(rx_data), 0);
        end else begin
          logic [11:0] e;
          string tg;
          e = q_rx.pop_front();
          tg = t_rx.pop_front();
          check(rx_data == e[8:0], tg, "rx data", int'(rx_data), int'(e[8:0]));
          check(rx_flags == e[11:9], tg, "rx flags", int'(rx_flags), int'(e[11:9]));
          check(rx_chan == 1'b0, "R9", "rx chan", int'(rx_chan), 0);
        end
      end
      if (tx_valid) begin
        if (q_tx.size() == 0) begin
          check(0, "R9", "unexpected tx result", int'(tx_data), 0);
        end else begin
          logic [11:0] e;
          string tg;
          e = q_tx.pop_front();
          tg = t_tx.pop_front();
          check(tx_data == e[8:0], tg, "tx data", int'(tx_data), int'(e[8:0]));
          check(tx_flags == e[11:9], tg, "tx flags", int'(tx_flags), int'(e[11:9]));
          check(tx_chan == 1'b1, "R9", "tx chan", int'(tx_chan), 1);
        end
      end
    end
  end

  task automatic set_cfg(input int per, input int len, input int par, input bit msb);
    cfg_period = 20'(per);
    cfg_len = 4'(len);
    cfg_parity = 3'(par);
    cfg_msb_first = msb;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(rx_valid == 1'b0, "R10", "rx_valid in reset", int'(rx_valid), 0);
    check(tx_valid == 1'b0, "R10", "tx_valid in reset", int'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_valid == 1'b0 && tx_valid == 1'b0, "R10", "valids after reset",
          int'({rx_valid, tx_valid}), 0);
    // R1: line low from reset must not start a frame (monitor flags any result).
    repeat (60) @(negedge clk);
    rx_line = 1'b1;
    repeat (6) @(negedge clk);

    // R2 R4 R6: 8 bits, no parity, LSB first, integer period
    send_frame(0, 'hA5, 8, 0, 0, 0, 0, 0, "R6");
    send_frame(1, 'h3C, 8, 0, 0, 0, 0, 0, "R2");
    send_frame(0, 'h01, 8, 0, 0, 0, 0, 0, "R4");
    set_cfg(2048, 8, 0, 1);
    send_frame(0, 'hB2, 8, 0, 1, 0, 0, 0, "R4");
    // R3: length extremes
    set_cfg(2048, 5, 0, 0);
    send_frame(0, 'h13, 5, 0, 0, 0, 0, 0, "R3");
    set_cfg(2048, 9, 0, 1);
    send_frame(1, 'h1A5, 9, 0, 1, 0, 0, 0, "R3");
    // R5: parity rules, good and bad
    set_cfg(2048, 8, 1, 0);
    send_frame(0, 'h5B, 8, 1, 0, 0, 0, 0, "R5");
    send_frame(0, 'h5B, 8, 1, 0, 0, 1, 0, "R5");
    set_cfg(2048, 8, 2, 0);
    send_frame(0, 'h5B, 8, 2, 0, 0, 0, 0, "R5");
    send_frame(1, 'h0F, 8, 2, 0, 0, 1, 0, "R5");
    set_cfg(2048, 7, 3, 0);
    send_frame(0, 'h6D, 7, 3, 0, 0, 0, 0, "R5");
    send_frame(0, 'h6D, 7, 3, 0, 0, 1, 0, "R5");
    set_cfg(2048, 6, 4, 1);
    send_frame(1, 'h2A, 6, 4, 1, 0, 0, 0, "R5");
    send_frame(1, 'h2A, 6, 4, 1, 0, 1, 0, "R5");
    // R7 / R8: bad start and bad stop
    set_cfg(2048, 8, 0, 0);
    send_frame(0, 'hC3, 8, 0, 0, 1, 0, 0, "R7");
    send_frame(0, 'h96, 8, 0, 0, 0, 0, 1, "R8");
    set_cfg(2048, 8, 2, 0);
    send_frame(1, 'h71, 8, 2, 0, 0, 0, 1, "R8");
    // R9: both lines at once
    set_cfg(2048, 8, 1, 0);
    fork
      send_frame(0, 'h55, 8, 1, 0, 0, 0, 0, "R9");
      send_frame(1, 'hAA, 8, 1, 0, 0, 1, 0, "R9");
    join
    // R2: fractional periods over a 12-bit frame
    set_cfg(1664, 9, 2, 0);
    send_frame(0, 'h15B, 9, 2, 0, 0, 0, 0, "R2");
    send_frame(1, 'h0C7, 9, 2, 0, 0, 0, 0, "R2");
    set_cfg(1472, 9, 1, 1);
    send_frame(0, 'h1E4, 9, 1, 1, 0, 0, 0, "R2");
    repeat (30) @(negedge clk);
    check(q_rx.size() == 0, "R9", "rx results missing", q_rx.size(), 0);
    check(q_tx.size() == 0, "R9", "tx results missing", q_tx.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule